// File: doc/BRIEF.md
# Multi-Level Configurable Channel Arbiter

The block picks one winner among a set of channel requesters each time an arbitrate strobe arrives. Every channel presents a request bit and a 2-bit priority level. The four levels are served strictly, highest level first. Inside one level the competing channels are ordered either statically or in round-robin fashion. A per-level mode bit in a 32-bit control register chooses the scheme, and a per-level 4-bit position field sits beside it.

The position field has one meaning in each mode. In round-robin mode it records the channel that last won at that level, and the next search begins just after it. In static mode it names the channel that ranks first. The ranking then falls through the higher channel numbers, wraps past the top channel to channel 0, and ends at the channel just below the named one. Clearing the mode bit leaves the field untouched, so the last round-robin winner becomes the static starting point. The winning index is registered and comes out one clock after the strobe.

Top module: `chan_arbiter`

## Requirements
- R1: After reset the control register reads 0x00000000 and `grant_vld` is low.
- R2: Level L owns byte L of the control register. Bit 8L+7 is its round-robin enable, bits 8L+3..8L+0 are its position field, and bits 8L+6..8L+4 ignore writes and always read zero.
- R3: Channel c takes its level from `req_lvl[2c+1:2c]`. A requesting channel at a higher level always wins over any requesting channel at a lower level.
- R4: For a static level with position x, channel x ranks first and the order is x, x+1, ..., n-1, 0, ..., x-1. With x = 0 this is plain ascending order.
- R5: For a round-robin level the search starts at the channel after the stored position and wraps modulo n. The winner's number is written into that level's position field.
- R6: A position field changes only when a channel of its own level wins while that level is in round-robin mode. Static levels and levels that did not win keep their fields.
- R7: Writing a level's enable bit to 0 keeps the position field, and the next static arbitration at that level starts from it.
- R8: A strobe with no active request leaves `grant_vld` low and changes no position field.
- R9: `grant_vld` is high in exactly the cycle after a strobe that found a winner. `grant_idx` then holds the winner and keeps it until the next grant.
- R10: Position values of n or above are read back as written and are used modulo n.
- R11: When a register write and a round-robin position update land on the same clock edge, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_CH | Per-channel request |
| req_lvl | input | 2*N_CH | Per-channel priority level, 2 bits per channel |
| arb_go | input | 1 | Arbitrate strobe |
| grant_vld | output | 1 | Grant valid, one cycle after a successful strobe |
| grant_idx | output | 4 | Granted channel number |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |

## Verification
The bench uses a non-zero static start so that the wrap from the top channel back to channel 0 is tested. A design that ignored the position field in static mode would grant the lowest requester instead. Round-robin pointers are tracked through consecutive strobes that are separated by idle cycles, which catches an off-by-one start, a pointer that moves with no strobe, and a pointer updated at the wrong level. The bench clears a mode bit while keeping the field and then runs a static strobe from the old pointer. It also stores a field value above the channel count and writes on the same edge as a grant, so a design that cleared the field, did not apply the modulo, or let the update beat the write would give a different index or read-back value.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int LVLS  = 4;
  localparam int LVL_W = 2;
  localparam int PTR_W = 4;
  localparam int CFG_W = 32;
  localparam int BYTE_W = CFG_W / LVLS;

  // First channel to examine in a level: the stored position itself in
  // static mode, the one after it in round-robin mode, always modulo n.
  function automatic int unsigned first_slot(logic [PTR_W-1:0] pos,
                                             logic rr, int unsigned n);
    int unsigned base;
    base = int'(pos) % n;
    return rr ? (base + 1) % n : base;
  endfunction
endpackage

// File: rtl/arb_level_pick.sv
module arb_level_pick #(
  parameter int N_CH = 16,
  localparam int PW = arb_pkg::PTR_W
) (
  input  logic [N_CH-1:0] cand,
  input  logic [PW-1:0]   start,
  output logic            hit,
  output logic [PW-1:0]   idx
);
  logic [2*N_CH-1:0] dbl;
  logic [N_CH-1:0]   rot;
  logic [PW-1:0]     off;
  logic [PW:0]       sum;

  assign dbl = {cand, cand};
  assign rot = N_CH'(dbl >> start);

  always_comb begin
    hit = 1'b0;
    off = '0;
    for (int k = N_CH - 1; k >= 0; k--) begin
      if (rot[k]) begin
        hit = 1'b1;
        off = PW'(k);
      end
    end
    sum = {1'b0, start} + {1'b0, off};
    if (sum >= (PW+1)'(N_CH)) sum = sum - (PW+1)'(N_CH);
    idx = sum[PW-1:0];
  end
endmodule

// File: rtl/arb_prio_reg.sv
module arb_prio_reg #(
  localparam int NL = arb_pkg::LVLS,
  localparam int PW = arb_pkg::PTR_W,
  localparam int CW = arb_pkg::CFG_W,
  localparam int BW = arb_pkg::BYTE_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [CW-1:0]  wdata,
  input  logic [NL-1:0]  upd_v,
  input  logic [PW-1:0]  upd_idx,
  output logic [NL-1:0]  rr_en,
  output logic [NL*PW-1:0] pos,
  output logic [CW-1:0]  rdata
);
  for (genvar L = 0; L < NL; L++) begin : g_lvl
    logic          en_q;
    logic [PW-1:0] pos_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q  <= 1'b0;
        pos_q <= '0;
      end else if (we) begin
        en_q  <= wdata[L*BW + BW - 1];
        pos_q <= wdata[L*BW +: PW];
      end else if (upd_v[L]) begin
        pos_q <= upd_idx;
      end
    end

    assign rr_en[L]       = en_q;
    assign pos[L*PW +: PW] = pos_q;
    assign rdata[L*BW +: BW] = {en_q, (BW-PW-1)'(0), pos_q};

    AST_RR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && upd_v[L]) |=> (pos_q == $past(upd_idx)));  // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (pos_q == $past(wdata[L*BW +: PW]) && en_q == $past(wdata[L*BW + BW - 1])));  // R11
  end

  AST_POS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && upd_v == '0) |=> $stable(pos));  // R6
endmodule

// File: rtl/chan_arbiter.sv
module chan_arbiter #(
  parameter int N_CH = 16,
  localparam int NL = arb_pkg::LVLS,
  localparam int LW = arb_pkg::LVL_W,
  localparam int PW = arb_pkg::PTR_W,
  localparam int CW = arb_pkg::CFG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CH-1:0]    req,
  input  logic [LW*N_CH-1:0] req_lvl,
  input  logic               arb_go,
  output logic               grant_vld,
  output logic [PW-1:0]      grant_idx,
  input  logic               cfg_we,
  input  logic [CW-1:0]      cfg_wdata,
  output logic [CW-1:0]      cfg_rdata
);
  logic [NL-1:0]    rr_en;
  logic [NL*PW-1:0] pos;
  logic [NL-1:0]    lvl_hit;
  logic [PW-1:0]    lvl_idx [NL];
  logic             any_hit;
  logic [LW-1:0]    win_lvl;
  logic [PW-1:0]    win_idx;
  logic [NL-1:0]    upd_v;
  logic             take;

  for (genvar L = 0; L < NL; L++) begin : g_pick
    logic [N_CH-1:0] cand;
    logic [PW-1:0]   start;
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign cand[c] = req[c] && (req_lvl[c*LW +: LW] == LW'(L));
    end
    assign start = PW'(arb_pkg::first_slot(pos[L*PW +: PW], rr_en[L], N_CH));
    arb_level_pick #(.N_CH(N_CH)) u_pick (
      .cand  (cand),
      .start (start),
      .hit   (lvl_hit[L]),
      .idx   (lvl_idx[L])
    );
  end

  // Ascending scan with overwrite: the highest level that has a hit wins.
  always_comb begin
    any_hit = 1'b0;
    win_lvl = '0;
    win_idx = '0;
    for (int L = 0; L < NL; L++) begin
      if (lvl_hit[L]) begin
        any_hit = 1'b1;
        win_lvl = LW'(L);
        win_idx = lvl_idx[L];
      end
    end
  end

  assign take = arb_go && any_hit;

  always_comb begin
    for (int L = 0; L < NL; L++)
      upd_v[L] = take && (win_lvl == LW'(L)) && rr_en[L];
  end

  arb_prio_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .upd_v   (upd_v),
    .upd_idx (win_idx),
    .rr_en   (rr_en),
    .pos     (pos),
    .rdata   (cfg_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_vld <= 1'b0;
      grant_idx <= '0;
    end else begin
      grant_vld <= take;
      if (take) grant_idx <= win_idx;
    end
  end

  logic [N_CH-1:0] gnt_oh;
  assign gnt_oh = N_CH'(1) << grant_idx;

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> |($past(req) & gnt_oh));  // R3
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_go |=> !grant_vld);  // R9
  AST_EMPTY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_go && req == '0) |=> !grant_vld);  // R8
  AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_v));  // R6
endmodule

// File: tb/sim_chan_arbiter.sv
module sim_chan_arbiter;
  localparam int CLK_P = 10;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [2*N-1:0] lvl = '0;
  logic go = 1'b0, we = 1'b0;
  logic [31:0] wd = '0;
  logic grant_vld;
  logic [3:0] grant_idx;
  logic [31:0] cfg_rdata;

  chan_arbiter #(.N_CH(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_lvl(lvl), .arb_go(go),
    .grant_vld(grant_vld), .grant_idx(grant_idx),
    .cfg_we(we), .cfg_wdata(wd), .cfg_rdata(cfg_rdata));

  always #(CLK_P/2) clk = ~clk;

  int m_en [4];
  int m_pos [4];
  bit e_vld;
  int e_idx;
  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  function automatic int ch_lvl(int c);
    return int'(lvl[2*c +: 2]);
  endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] v = '0;
    for (int l = 0; l < 4; l++) begin
      v[8*l+7] = m_en[l][0];
      v[8*l +: 4] = m_pos[l][3:0];
    end
    return v;
  endfunction

  task automatic model_edge();
    int found = -1, fl = 0, st;
    if (!rst_n) begin
      for (int l = 0; l < 4; l++) begin m_en[l] = 0; m_pos[l] = 0; end
      e_vld = 0; e_idx = 0;
      return;
    end
    if (go) begin
      for (int l = 3; l >= 0; l--) begin
        if (found < 0) begin
          st = m_en[l] != 0 ? (m_pos[l] % N + 1) % N : m_pos[l] % N;
          for (int k = 0; k < N; k++) begin
            if (found < 0 && req[(st+k)%N] && ch_lvl((st+k)%N) == l) begin
              found = (st+k)%N; fl = l;
            end
          end
        end
      end
    end
    e_vld = found >= 0;
    if (found >= 0) begin
      e_idx = found;
      if (m_en[fl] != 0) m_pos[fl] = found;
    end
    if (we) begin
      for (int l = 0; l < 4; l++) begin
        m_en[l] = int'(wd[8*l+7]);
        m_pos[l] = int'(wd[8*l +: 4]);
      end
    end
  endtask

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("grant_vld", int'(grant_vld), int'(e_vld));
    if (e_vld) chk("grant_idx", int'(grant_idx), e_idx);
    chk("cfg_rdata", int'(cfg_rdata), int'(exp_rd()));
  endtask

  task automatic drv(logic [N-1:0] r, logic g, logic w, logic [31:0] d);
    req = r; go = g; we = w; wd = d;
    cyc();
    go = 1'b0; we = 1'b0;
  endtask

  task automatic set_all_lvl(int v);
    for (int c = 0; c < N; c++) lvl[2*c +: 2] = 2'(v);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1"; cyc(); cyc();
    rst_n = 1'b1; cyc();

    tag = "R2";
    drv('0, 0, 1, 32'hFFFF_FFFF);
    drv('0, 0, 0, '0);
    drv('0, 0, 1, 32'h0000_0000);

    tag = "R4"; set_all_lvl(0);
    drv(12'b1010_0000_1000, 1, 0, '0);
    drv('0, 0, 1, 32'h0000_0005);
    drv(12'b0000_1000_0100, 1, 0, '0);
    drv(12'b0000_0000_1100, 1, 0, '0);
    drv(12'b1000_0000_0001, 1, 0, '0);
    drv(12'b0000_0001_0001, 1, 0, '0);

    tag = "R3"; set_all_lvl(0);
    lvl[2*1 +: 2] = 2'd1; lvl[2*4 +: 2] = 2'd3; lvl[2*9 +: 2] = 2'd2;
    drv(12'b0010_0001_0011, 1, 0, '0);
    drv(12'b0010_0000_0011, 1, 0, '0);
    drv(12'b0000_0000_0011, 1, 0, '0);

    tag = "R5"; set_all_lvl(2);
    drv('0, 0, 1, 32'h0080_0000);
    for (int i = 0; i < 5; i++) begin
      drv('1, 1, 0, '0);
      tag = "R9"; drv('1, 0, 0, '0); tag = "R5";
    end
    drv(12'b1000_0000_0001, 1, 0, '0);
    drv(12'b1000_0000_0001, 1, 0, '0);

    tag = "R6"; lvl[2*3 +: 2] = 2'd1;
    drv('0, 0, 1, 32'h0083_8005);
    drv(12'b0000_0000_1000, 1, 0, '0);
    drv(12'b0000_0000_1001, 1, 0, '0);

    tag = "R7";
    drv('0, 0, 1, {8'h00, 4'h0, m_pos[2][3:0], 8'h00, 8'h00});
    drv('1 & ~12'b1000, 1, 0, '0);
    drv('1 & ~12'b1000, 1, 0, '0);

    tag = "R8";
    drv('0, 1, 0, '0);
    drv('0, 1, 0, '0);

    tag = "R10"; set_all_lvl(1);
    drv('0, 0, 1, 32'h0000_0D00);
    drv(12'b0000_0010_0001, 1, 0, '0);
    drv('0, 0, 1, 32'h0000_8B00);
    drv(12'b0000_0010_0001, 1, 0, '0);
    drv(12'b0000_0010_0001, 1, 0, '0);

    tag = "R11";
    drv(12'b0000_0010_0001, 1, 1, 32'h0000_8200);
    drv(12'b0000_0010_0001, 1, 0, '0);

    tag = "R9";
    drv(12'b0000_0010_0001, 0, 0, '0);
    drv('0, 0, 0, '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule